// File: doc/BRIEF.md
# In-Memory MAC Tile Sequencer

This block sits in the execute stage of a vector core, next to the regular vector functional units. It receives already-decoded custom instructions and turns each one into commands for an in-memory multiply-accumulate tile. There are exactly four operations:

- fill one of the tile's weight rows;
- fill the tile's input buffer with a feature vector;
- kick off a computation;
- return the accumulated sum to a vector register.

Tile rows and the input buffer are 1024 bits wide, while the register file supplies operands 256 bits at a time. For a load, the sequencer collects four such stripes before it commits a row. For a write-back, it waits for the tile's result and widens the 24-bit sum to a 32-bit element.

The pipeline talks to the block through a valid/ready instruction port. Ready drops while a load is collecting stripes or a write-back is waiting, so instructions complete strictly in the order they were issued. A per-element mask travels with each instruction. Masked-off elements are not written into the tile, and a masked-off result element is not written to the register file. A write-back that has no outstanding computation completes at once with an error flag and a zero value.

Top module: `mac_tile_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `ins_ready` is 1 and `st_ready`, `tw_en`, `tc_start` and `wb_done` are 0.
- R2: A load (opcode 00 = weight row, 01 = feature vector) accepts exactly four stripes while `st_ready` is 1. Idle cycles in `st_valid` extend the load. `tw_en` pulses for one cycle, in the cycle after the edge that took the fourth stripe.
- R3: The stripe accepted as beat b (0 to 3) lands in `tw_data[256*b+255:256*b]`. `tw_row` carries the instruction's row index (0 to 31), and `tw_sel` is 0 for a weight row and 1 for the input buffer.
- R4: Bit i of `ins_mask` appears as `tw_elem_en[i]` and covers element i, which is `tw_data[32*i+31:32*i]`. A tile element whose enable is 0 keeps its previous content.
- R5: A compute instruction (opcode 10) produces a one-cycle `tc_start` pulse in the cycle after acceptance. `tc_prec` copies `ins_prec` unchanged (00 = 4-bit, 01 = 2-bit, 10 = 1-bit) and `tc_relu` copies `ins_relu`.
- R6: A write-back (opcode 11) holds `ins_ready` low until the result of the last compute is available. The result may arrive before the write-back, in the cycle the write-back is evaluated, or later. `wb_done` pulses in the cycle after the edge at which the result is available.
- R7: `wb_data` is the 24-bit tile sum sign-extended to 32 bits.
- R8: A write-back with no compute outstanding completes one cycle after acceptance with `wb_err` = 1 and `wb_data` = 0. A compute is outstanding from its issue until the write-back that consumes it. A result pulse that arrives while no compute is outstanding is ignored.
- R9: `wb_we` equals bit 0 of the write-back instruction's mask, and `wb_vd` carries its destination register index.
- R10: An instruction presented while the block is busy is held off with `ins_ready` = 0. It is accepted in the first cycle the block is idle again, after the earlier instruction has committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Decoded instruction present |
| ins_ready | output | 1 | Sequencer can accept an instruction |
| ins_op | input | 2 | 00 load weight, 01 load feature, 10 compute, 11 write-back |
| ins_row | input | 5 | Weight row index for loads |
| ins_vd | input | 5 | Destination vector register for write-back |
| ins_prec | input | 2 | Precision code for compute |
| ins_relu | input | 1 | Rectifier enable for compute |
| ins_mask | input | 32 | Per-element mask |
| st_valid | input | 1 | Register-file stripe present |
| st_ready | output | 1 | Sequencer is collecting stripes |
| st_data | input | 256 | Register-file stripe |
| tw_en | output | 1 | Tile row write strobe |
| tw_sel | output | 1 | 0 weight row, 1 input buffer |
| tw_row | output | 5 | Weight row index |
| tw_data | output | 1024 | Assembled row |
| tw_elem_en | output | 32 | Per-element write enables |
| tc_start | output | 1 | Tile compute start |
| tc_prec | output | 2 | Tile precision code |
| tc_relu | output | 1 | Tile rectifier enable |
| t_res_valid | input | 1 | Tile result valid pulse |
| t_res | input | 24 | Tile accumulated sum |
| wb_done | output | 1 | Write-back completion pulse |
| wb_we | output | 1 | Register-file write enable for the result |
| wb_err | output | 1 | Write-back had no compute outstanding |
| wb_vd | output | 5 | Destination register index |
| wb_data | output | 32 | Sign-extended result |

## Verification
The tile's result pulse and the write-back's readiness test can land in the same cycle: the block is then already waiting, and the result must be taken from the tile port directly instead of from the holding register. The bench provokes this by raising `t_res_valid` in exactly the cycle after the write-back is accepted. It then expects `wb_done` one cycle later, carrying that pulse's value rather than a stale or zero one. The same reference model also covers a result that arrives early, one that arrives three cycles late, and a stray pulse with no compute outstanding, which must not revive a consumed result.

// File: rtl/mac_tile_seq_pkg.sv
package mac_tile_seq_pkg;
  typedef enum logic [1:0] {
    OP_LDW = 2'b00,
    OP_LDF = 2'b01,
    OP_CMP = 2'b10,
    OP_WB  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOAD,
    S_WAIT
  } state_e;
endpackage

// File: rtl/mac_stripe_gather.sv
module mac_stripe_gather #(
  parameter int STRIPE_W = 256,
  parameter int ROW_W    = 1024,
  parameter int ELEM_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [ROW_W/ELEM_W-1:0]   start_mask,
  input  logic                      beat_valid,
  output logic                      beat_ready,
  input  logic [STRIPE_W-1:0]       beat_data,
  output logic                      last_beat,
  output logic                      row_valid,
  output logic [ROW_W-1:0]          row_data,
  output logic [ROW_W/ELEM_W-1:0]   row_en
);
  localparam int BEATS = ROW_W / STRIPE_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int EPB   = STRIPE_W / ELEM_W;
  localparam int EPR   = ROW_W / ELEM_W;

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EPR-1:0]   mask_q;
  logic [STRIPE_W-1:0] slot_q    [BEATS];
  logic [EPB-1:0]      slot_en_q [BEATS];
  logic take;

  assign beat_ready = active_q;
  assign take       = active_q & beat_valid;
  assign last_beat  = take && (cnt_q == CNT_W'(BEATS - 1));

  // beat counter and control
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      mask_q    <= '0;
      row_valid <= 1'b0;
    end else begin
      row_valid <= last_beat;
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        mask_q   <= start_mask;
      end else if (take) begin
        if (last_beat) active_q <= 1'b0;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // stripe data storage, no reset so it maps to plain registers or RAM
  always_ff @(posedge clk) begin
    for (int b = 0; b < BEATS; b++) begin
      if (take && cnt_q == CNT_W'(b)) slot_q[b] <= beat_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BEATS; b++) slot_en_q[b] <= '0;
    end else begin
      for (int b = 0; b < BEATS; b++) begin
        if (take && cnt_q == CNT_W'(b)) slot_en_q[b] <= mask_q[b*EPB +: EPB];
      end
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    assign row_data[g*STRIPE_W +: STRIPE_W] = slot_q[g];
    assign row_en[g*EPB +: EPB]             = slot_en_q[g];
  end
endmodule

// File: rtl/mac_result_hold.sv
module mac_result_hold #(
  parameter int SUM_W  = 24,
  parameter int ELEM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              consume,
  input  logic              res_valid,
  input  logic [SUM_W-1:0]  res_sum,
  output logic              pending,
  output logic              avail,
  output logic [ELEM_W-1:0] value
);
  localparam int EXT_W = ELEM_W - SUM_W;

  logic             pend_q;
  logic             have_q;
  logic [SUM_W-1:0] sum_q;
  logic [SUM_W-1:0] pick;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      have_q <= 1'b0;
      sum_q  <= '0;
    end else if (arm) begin
      pend_q <= 1'b1;
      have_q <= 1'b0;
    end else if (consume) begin
      pend_q <= 1'b0;
      have_q <= 1'b0;
    end else if (pend_q && res_valid && !have_q) begin
      have_q <= 1'b1;
      sum_q  <= res_sum;
    end
  end

  assign pending = pend_q;
  assign avail   = pend_q & (have_q | res_valid);
  assign pick    = have_q ? sum_q : res_sum;
  assign value   = {{EXT_W{pick[SUM_W-1]}}, pick};
endmodule

// File: rtl/mac_tile_seq.sv
module mac_tile_seq
  import mac_tile_seq_pkg::*;
#(
  parameter int STRIPE_W = 256,
  parameter int ROW_W    = 1024,
  parameter int ELEM_W   = 32,
  parameter int SUM_W    = 24,
  parameter int ROWS     = 32,
  parameter int VREGS    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ins_valid,
  output logic                        ins_ready,
  input  logic [1:0]                  ins_op,
  input  logic [$clog2(ROWS)-1:0]     ins_row,
  input  logic [$clog2(VREGS)-1:0]    ins_vd,
  input  logic [1:0]                  ins_prec,
  input  logic                        ins_relu,
  input  logic [ROW_W/ELEM_W-1:0]     ins_mask,
  input  logic                        st_valid,
  output logic                        st_ready,
  input  logic [STRIPE_W-1:0]         st_data,
  output logic                        tw_en,
  output logic                        tw_sel,
  output logic [$clog2(ROWS)-1:0]     tw_row,
  output logic [ROW_W-1:0]            tw_data,
  output logic [ROW_W/ELEM_W-1:0]     tw_elem_en,
  output logic                        tc_start,
  output logic [1:0]                  tc_prec,
  output logic                        tc_relu,
  input  logic                        t_res_valid,
  input  logic [SUM_W-1:0]            t_res,
  output logic                        wb_done,
  output logic                        wb_we,
  output logic                        wb_err,
  output logic [$clog2(VREGS)-1:0]    wb_vd,
  output logic [ELEM_W-1:0]           wb_data
);
  localparam int ROW_AW = $clog2(ROWS);
  localparam int VR_AW  = $clog2(VREGS);

  state_e            state_q;
  op_e               op;
  logic              accept;
  logic              is_load;
  logic              is_cmp;
  logic              last_beat;
  logic              res_pend;
  logic              res_avail;
  logic [ELEM_W-1:0] res_value;
  logic              consume;
  logic              keep_q;
  logic [VR_AW-1:0]  vd_q;

  assign op        = op_e'(ins_op);
  assign ins_ready = (state_q == S_IDLE);
  assign accept    = ins_valid & ins_ready;
  assign is_load   = accept & ((op == OP_LDW) | (op == OP_LDF));
  assign is_cmp    = accept & (op == OP_CMP);
  assign consume   = (state_q == S_WAIT) & res_avail;

  mac_stripe_gather #(
    .STRIPE_W(STRIPE_W), .ROW_W(ROW_W), .ELEM_W(ELEM_W)
  ) u_gather (
    .clk(clk), .rst(rst), .start(is_load), .start_mask(ins_mask),
    .beat_valid(st_valid), .beat_ready(st_ready), .beat_data(st_data),
    .last_beat(last_beat), .row_valid(tw_en), .row_data(tw_data),
    .row_en(tw_elem_en)
  );

  mac_result_hold #(
    .SUM_W(SUM_W), .ELEM_W(ELEM_W)
  ) u_hold (
    .clk(clk), .rst(rst), .arm(is_cmp), .consume(consume),
    .res_valid(t_res_valid), .res_sum(t_res), .pending(res_pend),
    .avail(res_avail), .value(res_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      tw_sel   <= 1'b0;
      tw_row   <= '0;
      tc_start <= 1'b0;
      tc_prec  <= '0;
      tc_relu  <= 1'b0;
      wb_done  <= 1'b0;
      wb_we    <= 1'b0;
      wb_err   <= 1'b0;
      wb_vd    <= '0;
      wb_data  <= '0;
      keep_q   <= 1'b0;
      vd_q     <= '0;
    end else begin
      tc_start <= 1'b0;
      wb_done  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            unique case (op)
              OP_LDW, OP_LDF: begin
                state_q <= S_LOAD;
                tw_sel  <= (op == OP_LDF);
                tw_row  <= ROW_AW'(ins_row);
              end
              OP_CMP: begin
                tc_start <= 1'b1;
                tc_prec  <= ins_prec;
                tc_relu  <= ins_relu;
              end
              OP_WB: begin
                state_q <= S_WAIT;
                vd_q    <= ins_vd;
                keep_q  <= ins_mask[0];
              end
              default: ;
            endcase
          end
        end
        S_LOAD: begin
          if (last_beat) state_q <= S_IDLE;
        end
        S_WAIT: begin
          if (!res_pend) begin
            state_q <= S_IDLE;
            wb_done <= 1'b1;
            wb_err  <= 1'b1;
            wb_data <= '0;
            wb_we   <= keep_q;
            wb_vd   <= vd_q;
          end else if (res_avail) begin
            state_q <= S_IDLE;
            wb_done <= 1'b1;
            wb_err  <= 1'b0;
            wb_data <= res_value;
            wb_we   <= keep_q;
            wb_vd   <= vd_q;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_tile_seq_chk.sv
module mac_tile_seq_chk #(
  parameter int STRIPE_W = 256,
  parameter int ROW_W    = 1024,
  parameter int ELEM_W   = 32,
  parameter int SUM_W    = 24,
  parameter int ROWS     = 32,
  parameter int VREGS    = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     ins_valid,
  input logic                     ins_ready,
  input logic [1:0]               ins_op,
  input logic                     st_ready,
  input logic                     tw_en,
  input logic                     tc_start,
  input logic                     wb_done,
  input logic                     wb_err,
  input logic [ELEM_W-1:0]        wb_data
);
  localparam int EXT_W = ELEM_W - SUM_W;

  // R1: outputs quiet right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (ins_ready && !st_ready && !tw_en && !tc_start && !wb_done));

  // R2: row commit is a single-cycle strobe
  a_r2_commit_pulse: assert property (@(posedge clk) disable iff (rst)
    tw_en |=> !tw_en);

  // R10: no instruction accepted while stripes are being gathered
  a_r10_busy_holdoff: assert property (@(posedge clk) disable iff (rst)
    st_ready |-> !ins_ready);

  // R5: start pulse only follows an accepted compute
  a_r5_start_follows: assert property (@(posedge clk) disable iff (rst)
    tc_start |-> $past(ins_valid && ins_ready && ins_op == 2'b10));

  // R6: completion only after a busy cycle
  a_r6_done_after_wait: assert property (@(posedge clk) disable iff (rst)
    wb_done |-> $past(!ins_ready));

  // R7: upper bits replicate the sum's sign bit
  a_r7_sign_ext: assert property (@(posedge clk) disable iff (rst)
    (wb_done && !wb_err) |-> (wb_data[ELEM_W-1:SUM_W] == {EXT_W{wb_data[SUM_W-1]}}));

  // R8: error completion returns zero
  a_r8_err_zero: assert property (@(posedge clk) disable iff (rst)
    (wb_done && wb_err) |-> (wb_data == '0));
endmodule

bind mac_tile_seq mac_tile_seq_chk #(
  .STRIPE_W(STRIPE_W), .ROW_W(ROW_W), .ELEM_W(ELEM_W),
  .SUM_W(SUM_W), .ROWS(ROWS), .VREGS(VREGS)
) u_chk (.*);

// File: tb/mac_tile_seq_bench.sv
module mac_tile_seq_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, ins_valid, ins_ready, ins_relu, st_valid, st_ready;
  logic [1:0] ins_op, ins_prec, tc_prec;
  logic [4:0] ins_row, ins_vd, tw_row, wb_vd;
  logic [31:0] ins_mask, tw_elem_en, wb_data;
  logic [255:0] st_data;
  logic tw_en, tw_sel, tc_start, tc_relu, t_res_valid, wb_done, wb_we, wb_err;
  logic [1023:0] tw_data;
  logic [23:0] t_res;

  mac_tile_seq u_mac_tile_seq (.*);

  int n_tests = 0, n_fail = 0;
  bit done_flag = 0;
  logic m_ready = 1, m_load = 0, m_tw = 0, m_tc = 0, m_wb = 0, mon_on = 0;
  bit m_pend = 0;
  logic [23:0] m_val = '0;

  logic [1023:0] tile_w [32];
  logic [1023:0] tile_in;
  logic [1023:0] exp_w [32];
  logic [1023:0] exp_in;

  task automatic chk(input bit ok, input string tag, input logic [1023:0] act, input logic [1023:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // bench-side tile: applies row writes with element enables
  always @(posedge clk) begin
    if (!rst && tw_en) begin
      for (int i = 0; i < 32; i++) begin
        if (tw_elem_en[i]) begin
          if (tw_sel) tile_in[i*32 +: 32] <= tw_data[i*32 +: 32];
          else tile_w[tw_row][i*32 +: 32] <= tw_data[i*32 +: 32];
        end
      end
    end
  end

  // every-clock comparison against the reference model
  always @(negedge clk) begin
    if (mon_on) begin
      chk(ins_ready === m_ready, "R10 ins_ready", 1024'(ins_ready), 1024'(m_ready));
      chk(st_ready === m_load, "R2 st_ready", 1024'(st_ready), 1024'(m_load));
      chk(tw_en === m_tw, "R2 tw_en", 1024'(tw_en), 1024'(m_tw));
      chk(tc_start === m_tc, "R5 tc_start", 1024'(tc_start), 1024'(m_tc));
      chk(wb_done === m_wb, "R6 wb_done", 1024'(wb_done), 1024'(m_wb));
    end
  end

  function automatic logic [31:0] elem(input int seed, input int i);
    return {8'(seed), 8'(i), 16'hA5C3 ^ 16'(seed * 7 + i)};
  endfunction

  function automatic logic [31:0] sext(input logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction

  task automatic do_load(input bit feat, input int row, input logic [31:0] mask, input int seed,
                         input bit gap, input bit queue_cmp, input logic [1:0] prec, input bit relu);
    logic [1023:0] full;
    for (int i = 0; i < 32; i++) full[i*32 +: 32] = elem(seed, i);
    ins_valid = 1; ins_op = feat ? 2'b01 : 2'b00; ins_row = 5'(row); ins_mask = mask;
    @(posedge clk); #1;
    m_ready = 0; m_load = 1;
    if (queue_cmp) begin
      ins_op = 2'b10; ins_prec = prec; ins_relu = relu; ins_row = '0;
    end else ins_valid = 0;
    for (int b = 0; b < 4; b++) begin
      if (gap && b == 2) begin
        st_valid = 0; @(posedge clk); #1;
      end
      st_valid = 1; st_data = full[b*256 +: 256];
      @(posedge clk); #1;
    end
    st_valid = 0; m_load = 0; m_ready = 1; m_tw = 1;
    @(negedge clk);
    chk(tw_data === full, "R3 row data", tw_data, full);
    chk(tw_elem_en === mask, "R4 element enables", 1024'(tw_elem_en), 1024'(mask));
    chk(tw_row === 5'(row) || feat, "R3 row index", 1024'(tw_row), 1024'(row));
    chk(tw_sel === feat, "R3 select", 1024'(tw_sel), 1024'(feat));
    for (int i = 0; i < 32; i++) begin
      if (mask[i]) begin
        if (feat) exp_in[i*32 +: 32] = full[i*32 +: 32];
        else exp_w[row][i*32 +: 32] = full[i*32 +: 32];
      end
    end
    @(posedge clk); #1;
    m_tw = 0;
    if (queue_cmp) begin
      ins_valid = 0; m_tc = 1; m_pend = 1;
      @(negedge clk);
      chk(tc_prec === prec, "R10 R5 queued prec", 1024'(tc_prec), 1024'(prec));
      chk(tc_relu === relu, "R5 queued relu", 1024'(tc_relu), 1024'(relu));
      @(posedge clk); #1;
      m_tc = 0;
    end
  endtask

  task automatic do_cmp(input logic [1:0] prec, input bit relu);
    ins_valid = 1; ins_op = 2'b10; ins_prec = prec; ins_relu = relu;
    @(posedge clk); #1;
    ins_valid = 0; m_tc = 1; m_pend = 1;
    @(negedge clk);
    chk(tc_prec === prec, "R5 prec", 1024'(tc_prec), 1024'(prec));
    chk(tc_relu === relu, "R5 relu", 1024'(tc_relu), 1024'(relu));
    @(posedge clk); #1;
    m_tc = 0;
  endtask

  task automatic res_pulse(input logic [23:0] v);
    t_res_valid = 1; t_res = v;
    @(posedge clk); #1;
    t_res_valid = 0;
    if (m_pend) m_val = v;
  endtask

  // mode 0: result already delivered (or none), 1: same cycle as evaluation, 2: three cycles late
  task automatic do_wb(input int vd, input bit keep, input int mode, input logic [23:0] v);
    bit exp_err;
    logic [31:0] exp_d;
    exp_err = !m_pend;
    ins_valid = 1; ins_op = 2'b11; ins_vd = 5'(vd); ins_mask = {31'b0, keep};
    @(posedge clk); #1;
    ins_valid = 0; m_ready = 0;
    if (mode == 2) begin
      repeat (3) begin @(posedge clk); #1; end
    end
    if (mode != 0) begin t_res_valid = 1; t_res = v; m_val = v; end
    @(posedge clk); #1;
    t_res_valid = 0; m_wb = 1; m_ready = 1;
    exp_d = exp_err ? 32'h0 : sext(m_val);
    @(negedge clk);
    chk(wb_err === exp_err, "R8 error flag", 1024'(wb_err), 1024'(exp_err));
    chk(wb_data === exp_d, "R7 R8 result", 1024'(wb_data), 1024'(exp_d));
    chk(wb_we === keep, "R9 write enable", 1024'(wb_we), 1024'(keep));
    chk(wb_vd === 5'(vd), "R9 destination", 1024'(wb_vd), 1024'(vd));
    @(posedge clk); #1;
    m_wb = 0; m_pend = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int r = 0; r < 32; r++) begin tile_w[r] = '0; exp_w[r] = '0; end
    tile_in = '0; exp_in = '0;
    rst = 1; ins_valid = 0; ins_op = 0; ins_row = 0; ins_vd = 0; ins_prec = 0; ins_relu = 0;
    ins_mask = 0; st_valid = 0; st_data = 0; t_res_valid = 0; t_res = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(ins_ready === 1'b1, "R1 ready after reset", 1024'(ins_ready), 1024'(1));
    chk({st_ready, tw_en, tc_start, wb_done} === 4'b0, "R1 quiet after reset",
        1024'({st_ready, tw_en, tc_start, wb_done}), 1024'(0));
    mon_on = 1;
    @(posedge clk); #1;

    do_wb(3, 1, 0, 24'h0);                                  // R8 nothing outstanding
    do_load(0, 31, 32'hFFFF_FFFF, 1, 0, 0, 2'b00, 0);       // R2 R3
    do_load(0, 5, 32'hFFFF_FFFF, 2, 1, 0, 2'b00, 0);        // R2 gap in stripes
    do_load(0, 31, 32'h0F0F_00FF, 3, 0, 0, 2'b00, 0);       // R4 partial mask
    chk(tile_w[31] === exp_w[31], "R4 masked elements kept", tile_w[31], exp_w[31]);
    chk(tile_w[5] === exp_w[5], "R3 row 5 image", tile_w[5], exp_w[5]);
    do_load(1, 0, 32'hFFFF_0000, 4, 0, 1, 2'b01, 1);        // R10 queued compute
    chk(tile_in === exp_in, "R4 input buffer image", tile_in, exp_in);
    do_wb(7, 1, 2, 24'h01_2345);                            // R6 late result
    do_cmp(2'b10, 0);
    res_pulse(24'h80_0001);
    do_wb(9, 1, 0, 24'h0);                                  // R6 early result, R7 negative
    do_wb(4, 1, 0, 24'h0);                                  // R8 already consumed
    do_cmp(2'b00, 1);
    do_wb(12, 0, 1, 24'h7F_FFFF);                           // R6 same-cycle result, R9 masked
    res_pulse(24'h12_3456);                                 // R8 stray pulse ignored
    do_wb(2, 1, 0, 24'h0);
    repeat (2) @(posedge clk);
    summary();
  end
endmodule